// File: doc/BRIEF.md
# Transmit Input Mode and Line Idle Controller

This block decides how a line transceiver takes its transmit data and whether its line driver runs. It watches the two transmit data pins, the receive and transmit clocks, a mode pin, and a host control byte. From these it decides four things. The first is whether input is dual-rail (bipolar) or single-rail (unipolar). The second is whether zero-substitution (B8ZS) encoding is requested. The third is whether the transmit clock is still alive. The fourth is whether the line driver is enabled. The encoder, the jitter attenuator and the analog driver come after this block and are not part of it.

All logic runs on one core clock, `clk`, which must be several times faster than the line clocks. The receive clock, transmit clock, mode pin and data pins enter as asynchronous levels. Each passes through a synchronizer. A receive-clock "tick" is a synchronized rising edge of `rxClk`, and all cycle counts are in ticks. `hostSel`, `hostCtrl`, `sendOnes`, `loopRemote` and `loopNetwork` are static configuration inputs and are taken to be synchronous to `clk`.

Top module: `tx_mode_idle_ctrl`

## Requirements
- R1: While `rst` is high and right after it is released, `unipolar`, `b8zsOn`, `driverOn`, `railPos` and `railNeg` are all 0.
- R2: In bipolar mode, `railPos` follows `txDataA` and `railNeg` follows `txDataB`, with a fixed pipeline delay.
- R3: Bipolar mode switches to unipolar on the 16th consecutive tick at which `txDataB` is high. A tick at which `txDataB` is low restarts the count from zero.
- R4: In unipolar mode, `railPos` follows `txDataA` and `railNeg` is held at 0 whatever `txDataB` does.
- R5: Unipolar mode switches back to bipolar on the 16th consecutive tick at which `txDataB` is low. A tick at which it is high restarts that count.
- R6: When `hostSel` is 1, `b8zsOn` equals bit 3 of `hostCtrl`. The other seven bits have no effect on it.
- R7: When `hostSel` is 0, `b8zsOn` turns on after `hwModeIn` has matched the level of `rxClk` for 16 consecutive ticks. It turns off as soon as the two levels differ.
- R8: After 32 ticks without a rising edge of `txClk`, `driverOn` goes to 0. The next rising edge of `txClk` sets it back to 1. The transmit clock is treated as absent from reset until its first rising edge.
- R9: When any of `sendOnes`, `loopRemote` or `loopNetwork` is 1, `driverOn` is 1 even while the transmit clock is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| rxClk | input | 1 | Recovered receive clock, sampled as data |
| txClk | input | 1 | Transmit clock, sampled as data |
| txDataA | input | 1 | First transmit data pin (positive rail or single-rail data) |
| txDataB | input | 1 | Second transmit data pin (negative rail or mode strap) |
| hwModeIn | input | 1 | Hardware mode pin; tying it to the receive clock requests B8ZS |
| hostSel | input | 1 | 1 selects host control, 0 selects hardware control |
| hostCtrl | input | 8 | Host control byte; bit 3 requests B8ZS |
| sendOnes | input | 1 | All-ones transmit enable |
| loopRemote | input | 1 | Remote loopback enable |
| loopNetwork | input | 1 | Network loopback enable |
| railPos | output | 1 | Positive rail toward the encoder |
| railNeg | output | 1 | Negative rail toward the encoder |
| unipolar | output | 1 | 1 when single-rail input is active |
| b8zsOn | output | 1 | B8ZS encoding requested |
| driverOn | output | 1 | Line driver enable; 0 leaves the line in high impedance |

## Verification
The bench tests every count at its boundary. Mode entry, mode exit, mode-pin tie detection and clock loss are each checked one tick before the limit and again at the limit, so a counter that is off by one shows up as a wrong output at one of the two points. A low tick in the middle of a run of high ticks on `txDataB` must restart the count. A design that only pauses the count would enter unipolar mode too early. A mode pin that stops following the receive clock must drop B8ZS, and a design that latches the tie would keep it on. Each of the three driver overrides is tried alone while the transmit clock is stopped, so an override that is missing or wired to the wrong input leaves the driver off.

// File: rtl/tx_mode_pkg.sv
package tx_mode_pkg;

  // Synchronized observations passed from datapath to control
  typedef struct packed {
    logic rxTick;     // rising edge of receive clock
    logic txEdge;     // rising edge of transmit clock
    logic negHigh;    // synchronized second data pin
    logic modeMatch;  // mode pin level equals receive clock level
  } sense_t;

  // Decisions passed from control to datapath and outputs
  typedef struct packed {
    logic uniMode;
    logic b8zsEn;
    logic drvEn;
  } strobe_t;

endpackage

// File: rtl/tx_mode_datapath.sv
module tx_mode_datapath
  import tx_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    rxClk,
  input  logic    txClk,
  input  logic    txDataA,
  input  logic    txDataB,
  input  logic    hwModeIn,
  input  strobe_t strobe,
  output sense_t  sense,
  output logic    railPos,
  output logic    railNeg
);

  localparam int NUM_IN = 5;
  localparam int IDX_POS = 0;
  localparam int IDX_NEG = 1;
  localparam int IDX_RX = 2;
  localparam int IDX_TX = 3;
  localparam int IDX_MODE = 4;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_IN-1:0] syncOut;
  logic rxPrev;
  logic txPrev;

  assign rawIn = {hwModeIn, txClk, rxClk, txDataB, txDataA};

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) syncPipe[s] <= '0;
          else     syncPipe[s] <= rawIn;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (rst) syncPipe[s] <= '0;
          else     syncPipe[s] <= syncPipe[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rxPrev <= 1'b0;
      txPrev <= 1'b0;
    end else begin
      rxPrev <= syncOut[IDX_RX];
      txPrev <= syncOut[IDX_TX];
    end
  end

  always_comb begin
    sense.rxTick    = syncOut[IDX_RX] & ~rxPrev;
    sense.txEdge    = syncOut[IDX_TX] & ~txPrev;
    sense.negHigh   = syncOut[IDX_NEG];
    sense.modeMatch = syncOut[IDX_MODE] == syncOut[IDX_RX];
  end

  // Rail steering: single-rail mode forces the negative rail quiet
  always_ff @(posedge clk) begin
    if (rst) begin
      railPos <= 1'b0;
      railNeg <= 1'b0;
    end else begin
      railPos <= syncOut[IDX_POS];
      railNeg <= strobe.uniMode ? 1'b0 : syncOut[IDX_NEG];
    end
  end

endmodule

// File: rtl/tx_mode_control.sv
module tx_mode_control
  import tx_mode_pkg::*;
#(
  parameter int UNI_HOLD   = 16,
  parameter int TIE_LIMIT  = 16,
  parameter int LOST_LIMIT = 32,
  parameter int CTRL_W     = 8,
  parameter int B8ZS_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  sense_t            sense,
  input  logic              hostSel,
  input  logic [CTRL_W-1:0] hostCtrl,
  input  logic              sendOnes,
  input  logic              loopRemote,
  input  logic              loopNetwork,
  output strobe_t           strobe
);

  localparam int UNI_W  = $clog2(UNI_HOLD);
  localparam int TIE_W  = $clog2(TIE_LIMIT);
  localparam int LOST_W = $clog2(LOST_LIMIT);
  localparam logic [UNI_W-1:0]  UNI_LAST  = UNI_W'(UNI_HOLD - 1);
  localparam logic [TIE_W-1:0]  TIE_LAST  = TIE_W'(TIE_LIMIT - 1);
  localparam logic [LOST_W-1:0] LOST_LAST = LOST_W'(LOST_LIMIT - 1);

  logic [UNI_W-1:0]  uniCnt;
  logic [TIE_W-1:0]  tieCnt;
  logic [LOST_W-1:0] lostCnt;
  logic uniMode;
  logic tied;
  logic txLost;
  logic b8zsReg;
  logic drvReg;
  logic towardSwitch;

  // A tick counts toward a switch when the second pin sits at the
  // level that requests the other mode.
  assign towardSwitch = uniMode ? ~sense.negHigh : sense.negHigh;

  always_ff @(posedge clk) begin
    if (rst) begin
      uniCnt  <= '0;
      uniMode <= 1'b0;
    end else if (sense.rxTick) begin
      if (!towardSwitch) begin
        uniCnt <= '0;
      end else if (uniCnt == UNI_LAST) begin
        uniCnt  <= '0;
        uniMode <= ~uniMode;
      end else begin
        uniCnt <= uniCnt + 1'b1;
      end
    end
  end

  // Mode pin tied to the receive clock
  always_ff @(posedge clk) begin
    if (rst) begin
      tieCnt <= '0;
      tied   <= 1'b0;
    end else if (!sense.modeMatch) begin
      tieCnt <= '0;
      tied   <= 1'b0;
    end else if (sense.rxTick && !tied) begin
      if (tieCnt == TIE_LAST) tied <= 1'b1;
      else                    tieCnt <= tieCnt + 1'b1;
    end
  end

  // Transmit clock activity; absent from reset until first edge
  always_ff @(posedge clk) begin
    if (rst) begin
      lostCnt <= '0;
      txLost  <= 1'b1;
    end else if (sense.txEdge) begin
      lostCnt <= '0;
      txLost  <= 1'b0;
    end else if (sense.rxTick && !txLost) begin
      if (lostCnt == LOST_LAST) txLost <= 1'b1;
      else                      lostCnt <= lostCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b8zsReg <= 1'b0;
      drvReg  <= 1'b0;
    end else begin
      b8zsReg <= hostSel ? hostCtrl[B8ZS_BIT] : tied;
      drvReg  <= ~txLost | sendOnes | loopRemote | loopNetwork;
    end
  end

  always_comb begin
    strobe.uniMode = uniMode;
    strobe.b8zsEn  = b8zsReg;
    strobe.drvEn   = drvReg;
  end

endmodule

// File: rtl/tx_mode_idle_ctrl.sv
module tx_mode_idle_ctrl
  import tx_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int UNI_HOLD    = 16,
  parameter int TIE_LIMIT   = 16,
  parameter int LOST_LIMIT  = 32,
  parameter int CTRL_W      = 8,
  parameter int B8ZS_BIT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxClk,
  input  logic              txClk,
  input  logic              txDataA,
  input  logic              txDataB,
  input  logic              hwModeIn,
  input  logic              hostSel,
  input  logic [CTRL_W-1:0] hostCtrl,
  input  logic              sendOnes,
  input  logic              loopRemote,
  input  logic              loopNetwork,
  output logic              railPos,
  output logic              railNeg,
  output logic              unipolar,
  output logic              b8zsOn,
  output logic              driverOn
);

  sense_t  sense;
  strobe_t strobe;

  tx_mode_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .rxClk(rxClk), .txClk(txClk),
    .txDataA(txDataA), .txDataB(txDataB), .hwModeIn(hwModeIn),
    .strobe(strobe), .sense(sense), .railPos(railPos), .railNeg(railNeg)
  );

  tx_mode_control #(
    .UNI_HOLD(UNI_HOLD), .TIE_LIMIT(TIE_LIMIT), .LOST_LIMIT(LOST_LIMIT),
    .CTRL_W(CTRL_W), .B8ZS_BIT(B8ZS_BIT)
  ) u_ctl (
    .clk(clk), .rst(rst), .sense(sense), .hostSel(hostSel),
    .hostCtrl(hostCtrl), .sendOnes(sendOnes), .loopRemote(loopRemote),
    .loopNetwork(loopNetwork), .strobe(strobe)
  );

  assign unipolar = strobe.uniMode;
  assign b8zsOn   = strobe.b8zsEn;
  assign driverOn = strobe.drvEn;

endmodule

// File: rtl/tx_mode_checker.sv
module tx_mode_checker #(
  parameter int CTRL_W   = 8,
  parameter int B8ZS_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [CTRL_W-1:0] hostCtrl,
  input logic              hostSel,
  input logic              sendOnes,
  input logic              loopRemote,
  input logic              loopNetwork,
  input logic              railNeg,
  input logic              unipolar,
  input logic              b8zsOn,
  input logic              driverOn
);

  AST_UNI_NEG_QUIET: assert property (@(posedge clk) disable iff (rst)
    unipolar |=> !railNeg); // R4

  AST_OVERRIDE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (sendOnes || loopRemote || loopNetwork) |=> driverOn); // R9

  AST_HOST_B8ZS_BIT: assert property (@(posedge clk) disable iff (rst)
    hostSel |=> (b8zsOn == $past(hostCtrl[B8ZS_BIT]))); // R6

  AST_UNI_NO_CHATTER: assert property (@(posedge clk) disable iff (rst)
    $rose(unipolar) |=> unipolar); // R3

  AST_BIP_NO_CHATTER: assert property (@(posedge clk) disable iff (rst)
    $fell(unipolar) |=> !unipolar); // R5

endmodule

bind tx_mode_idle_ctrl tx_mode_checker #(.CTRL_W(CTRL_W), .B8ZS_BIT(B8ZS_BIT)) u_chk (
  .clk(clk), .rst(rst), .hostCtrl(hostCtrl), .hostSel(hostSel),
  .sendOnes(sendOnes), .loopRemote(loopRemote), .loopNetwork(loopNetwork),
  .railNeg(railNeg), .unipolar(unipolar), .b8zsOn(b8zsOn), .driverOn(driverOn)
);

// File: tb/tx_mode_idle_ctrl_tb.sv
module tx_mode_idle_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;          // core cycles per receive half period
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxClk = 1'b0, txClk = 1'b0, txDataA = 1'b0, txDataB = 1'b0;
  logic hwModeIn = 1'b0, hostSel = 1'b0;
  logic [7:0] hostCtrl = 8'h00;
  logic sendOnes = 1'b0, loopRemote = 1'b0, loopNetwork = 1'b0;
  logic railPos, railNeg, unipolar, b8zsOn, driverOn;

  logic txRun = 1'b0;
  logic modeTied = 1'b0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_mode_idle_ctrl u_dut (
    .clk(clk), .rst(rst), .rxClk(rxClk), .txClk(txClk),
    .txDataA(txDataA), .txDataB(txDataB), .hwModeIn(hwModeIn),
    .hostSel(hostSel), .hostCtrl(hostCtrl), .sendOnes(sendOnes),
    .loopRemote(loopRemote), .loopNetwork(loopNetwork),
    .railPos(railPos), .railNeg(railNeg), .unipolar(unipolar),
    .b8zsOn(b8zsOn), .driverOn(driverOn)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rxCycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxClk = 1'b1;
      if (txRun) txClk = ~txClk;
      if (modeTied) hwModeIn = 1'b1;
      waitClk(HALF);
      rxClk = 1'b0;
      if (modeTied) hwModeIn = 1'b0;
      waitClk(HALF - 1);
    end
    waitClk(2);
  endtask

  task automatic testReset();
    waitClk(3);
    chk("R1", "driverOn in reset", driverOn, 1'b0);
    rst = 1'b0;
    waitClk(SETTLE);
    chk("R1", "unipolar", unipolar, 1'b0);
    chk("R1", "b8zsOn", b8zsOn, 1'b0);
    chk("R1", "driverOn", driverOn, 1'b0);
    chk("R1", "railPos", railPos, 1'b0);
    chk("R1", "railNeg", railNeg, 1'b0);
  endtask

  task automatic testBipolar();
    txDataA = 1'b1; txDataB = 1'b0; waitClk(SETTLE);
    chk("R2", "railPos A=1", railPos, 1'b1);
    chk("R2", "railNeg B=0", railNeg, 1'b0);
    txDataA = 1'b0; txDataB = 1'b1; waitClk(SETTLE);
    chk("R2", "railPos A=0", railPos, 1'b0);
    chk("R2", "railNeg B=1", railNeg, 1'b1);
    txDataB = 1'b0; waitClk(SETTLE);
  endtask

  task automatic testUniEntry();
    txDataB = 1'b1; rxCycles(10);
    txDataB = 1'b0; rxCycles(1);
    txDataB = 1'b1; rxCycles(10);
    chk("R3", "after low restart, 10 high", unipolar, 1'b0);
    rxCycles(5);
    chk("R3", "15 high ticks", unipolar, 1'b0);
    rxCycles(1);
    chk("R3", "16 high ticks", unipolar, 1'b1);
  endtask

  task automatic testUniData();
    txDataA = 1'b1; txDataB = 1'b1; waitClk(SETTLE);
    chk("R4", "railPos from A", railPos, 1'b1);
    chk("R4", "railNeg quiet", railNeg, 1'b0);
    txDataA = 1'b0; waitClk(SETTLE);
    chk("R4", "railPos A=0", railPos, 1'b0);
  endtask

  task automatic testUniExit();
    txDataB = 1'b0; rxCycles(8);
    txDataB = 1'b1; rxCycles(1);
    txDataB = 1'b0; rxCycles(15);
    chk("R5", "15 low ticks after restart", unipolar, 1'b1);
    rxCycles(1);
    chk("R5", "16 low ticks", unipolar, 1'b0);
    txDataB = 1'b1; waitClk(SETTLE);
    chk("R5", "bipolar rail back", railNeg, 1'b1);
    txDataB = 1'b0; waitClk(SETTLE);
  endtask

  task automatic testTxLoss();
    txClk = 1'b0; txRun = 1'b1; rxCycles(4);
    chk("R8", "driver on with tx clock", driverOn, 1'b1);
    txClk = 1'b0; rxCycles(1);   // last rising edge coincides with a tick
    txRun = 1'b0;
    rxCycles(31);
    chk("R8", "31 ticks without edge", driverOn, 1'b1);
    rxCycles(1);
    chk("R8", "32 ticks without edge", driverOn, 1'b0);
    txClk = 1'b0; waitClk(2); txClk = 1'b1; waitClk(SETTLE);
    chk("R8", "edge restores driver", driverOn, 1'b1);
    txClk = 1'b0;
    rxCycles(33);
    chk("R8", "lost again", driverOn, 1'b0);
  endtask

  task automatic testOverrides();
    sendOnes = 1'b1; waitClk(3);
    chk("R9", "all-ones forces driver", driverOn, 1'b1);
    sendOnes = 1'b0; waitClk(3);
    chk("R9", "released", driverOn, 1'b0);
    loopRemote = 1'b1; waitClk(3);
    chk("R9", "remote loop forces driver", driverOn, 1'b1);
    loopRemote = 1'b0; loopNetwork = 1'b1; waitClk(3);
    chk("R9", "network loop forces driver", driverOn, 1'b1);
    loopNetwork = 1'b0; waitClk(3);
    chk("R9", "all released", driverOn, 1'b0);
  endtask

  task automatic testHost();
    hostSel = 1'b1; hostCtrl = 8'h08; waitClk(3);
    chk("R6", "bit3 set", b8zsOn, 1'b1);
    hostCtrl = 8'hF7; waitClk(3);
    chk("R6", "other bits set", b8zsOn, 1'b0);
    modeTied = 1'b1; rxCycles(20);
    chk("R6", "mode pin ignored in host mode", b8zsOn, 1'b0);
    modeTied = 1'b0; hwModeIn = 1'b0; hostSel = 1'b0; hostCtrl = 8'h00;
    waitClk(SETTLE);
  endtask

  task automatic testHardware();
    rxCycles(2);
    modeTied = 1'b1; rxCycles(15);
    chk("R7", "15 tied ticks", b8zsOn, 1'b0);
    rxCycles(1);
    chk("R7", "16 tied ticks", b8zsOn, 1'b1);
    modeTied = 1'b0; hwModeIn = 1'b1; rxCycles(2);
    chk("R7", "untied drops B8ZS", b8zsOn, 1'b0);
    hwModeIn = 1'b0;
  endtask

  initial begin
    testReset();
    testBipolar();
    testUniEntry();
    testUniData();
    testUniExit();
    testTxLoss();
    testOverrides();
    testHost();
    testHardware();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule